// File: doc/BRIEF.md
# NAND Flash Command and Data Phase Sequencer

This block turns one bus write or read into a train of NAND flash bus cycles on an 8-bit flash interface. The address of the bus transfer carries the whole operation: which chip to select, whether this is a command phase or a data phase, which command bytes to send, how many address bytes follow, and whether chip enable is released at the end. The 32-bit write data word supplies either address bytes (command phase) or payload bytes (data phase). A data-phase read returns a 32-bit word built from four flash bytes.

Software or an upstream bus adapter first issues a command-phase transfer (for example a read-page opcode, five address bytes and a confirm opcode). It then issues data-phase transfers that move four bytes each. Chip enable stays asserted between transfers, and the last one sets a release flag. Strobe timing is set by two parameters that give the low and high widths of each write or read strobe in clock cycles.

Top module: `nand_phase_seq`

## Requirements
- R1: Request address bit 19 selects the phase. When it is 0 the request is a command phase, which only drives write strobes. When it is 1 the request is a data phase.
- R2: A command phase first sends the start opcode from address bits [10:3] with CLE high. It then sends N address bytes with ALE high, where N is the value of address bits [23:21] (0 to 7). The address bytes come from the write data word, least significant byte first.
- R3: When N is greater than 4, the sequencer pauses after the fourth address byte and raises req_ready. It takes address bytes 5 to 7 from the write data of the next accepted request, least significant byte first, and ignores that request's address.
- R4: When address bit 20 is 1, an end opcode taken from bits [18:11] is sent with CLE high. It follows the address bytes in a command phase and the four data bytes in a data phase. When bit 20 is 0, no end opcode is sent.
- R5: A data-phase write sends the four bytes of the write data word, least significant byte first, with CLE and ALE both low.
- R6: A data-phase read pulses RE_n four times and samples the IO bus on the last low cycle of each pulse. It then raises rsp_valid for one cycle with the bytes packed little-endian: first byte in bits [7:0].
- R7: A data-phase read does not drive its first RE_n pulse while nand_rb is low (0 = busy).
- R8: A data-phase request with address bit 21 set deasserts every chip enable when it completes. Without that bit, and after any command phase, the selected chip enable stays low.
- R9: Address bits [24 +: log2(NUM_CE)] select the chip. On acceptance exactly that chip enable goes low and all the others go high. A strobe is only ever driven while some chip enable is low.
- R10: ecc_last equals address bit 10 of the last accepted data-phase request. It is 0 after a command phase, and it holds its value until the next request is accepted.
- R11: Each WE_n or RE_n pulse stays low for exactly PULSE_LOW cycles. CLE and ALE are never high together. WE_n and RE_n are never low together.
- R12: After reset all chip enables are high, CLE and ALE are low, WE_n and RE_n are high, the IO bus is released, and req_ready is high. req_ready is low while a sequence runs and is high only when idle or while waiting for a second address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a cycle where valid and ready are both high |
| req_addr | input | 32 | Encoded operation |
| req_write | input | 1 | 1 = write, 0 = read (data phase only) |
| req_wdata | input | 32 | Address bytes or payload |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 32 | Read word, little-endian |
| ecc_last | output | 1 | Sideband flag marking the last transfer of a protected block |
| nand_ce_n | output | NUM_CE | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, latches on rising edge |
| nand_re_n | output | 1 | Read strobe |
| nand_io | inout | 8 | Flash data bus |
| nand_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
A wrong step counter or opcode select shows up within the same sequence. The byte latched at the next WE_n rising edge carries the wrong CLE/ALE tag or value, and the sequence has too many or too few strobes before req_ready returns. A lost chip-enable or release state shows on nand_ce_n as soon as the request completes, and a bad ready/busy gate shows as an RE_n edge while nand_rb is still low. Read packing errors show in the single rsp_valid cycle that closes the read.

// File: rtl/nand_phase_seq.sv
module nand_phase_seq #(
  parameter int NUM_CE     = 4,
  parameter int PULSE_LOW  = 2,
  parameter int PULSE_HIGH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              ecc_last,
  output logic [NUM_CE-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  inout  wire  [7:0]        nand_io,
  input  logic              nand_rb
);
  localparam int CSW  = (NUM_CE > 1) ? $clog2(NUM_CE) : 1;
  localparam int TMAX = (PULSE_LOW > PULSE_HIGH) ? PULSE_LOW : PULSE_HIGH;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_WAIT2, S_RB} st_t;
  typedef enum logic [1:0] {K_CMD, K_ADDR, K_DATA, K_END} kind_t;

  st_t         st;
  kind_t       kind;
  logic [TW-1:0] tmr;
  logic [7:0]  op_start, op_end;
  logic [2:0]  naddr, idx;
  logic        end_v, is_data, clr_cs, rd_q;
  logic [31:0] wbuf;

  logic        unused_bits;
  assign unused_bits = ^{req_addr[2:0], req_addr[9:3], req_addr[31:24+CSW]};

  wire rd_op   = (kind == K_DATA) && rd_q;
  wire pulse   = (st == S_LOW) || (st == S_HIGH);
  wire last_hi = (st == S_HIGH) && (tmr == '0);

  logic done_now;
  always_comb begin
    done_now = 1'b0;
    if (last_hi) begin
      case (kind)
        K_CMD:  done_now = (naddr == 3'd0) && !end_v;
        K_ADDR: done_now = (idx + 3'd1 == naddr) && !end_v;
        K_DATA: done_now = (idx == 3'd3) && !end_v;
        K_END:  done_now = 1'b1;
      endcase
    end
  end

  logic [7:0] io_byte;
  always_comb begin
    case (kind)
      K_CMD:   io_byte = op_start;
      K_END:   io_byte = op_end;
      default: io_byte = wbuf[8*idx[1:0] +: 8];
    endcase
  end

  assign req_ready = (st == S_IDLE) || (st == S_WAIT2);
  assign nand_cle  = pulse && ((kind == K_CMD) || (kind == K_END));
  assign nand_ale  = pulse && (kind == K_ADDR);
  assign nand_we_n = !((st == S_LOW) && !rd_op);
  assign nand_re_n = !((st == S_LOW) && rd_op);
  assign nand_io   = (pulse && !rd_op) ? io_byte : 8'hzz;

  wire [CSW-1:0] sel = req_addr[24 +: CSW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_CMD;
      tmr       <= '0;
      op_start  <= '0;
      op_end    <= '0;
      naddr     <= '0;
      idx       <= '0;
      end_v     <= 1'b0;
      is_data   <= 1'b0;
      clr_cs    <= 1'b0;
      rd_q      <= 1'b0;
      wbuf      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ecc_last  <= 1'b0;
      nand_ce_n <= '1;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_start  <= req_addr[10:3];
          op_end    <= req_addr[18:11];
          end_v     <= req_addr[20];
          naddr     <= req_addr[23:21];
          is_data   <= req_addr[19];
          clr_cs    <= req_addr[21];
          rd_q      <= !req_write;
          wbuf      <= req_wdata;
          idx       <= '0;
          tmr       <= TW'(PULSE_LOW - 1);
          ecc_last  <= req_addr[19] & req_addr[10];
          nand_ce_n <= ~(NUM_CE'(1) << sel);
          if (!req_addr[19]) begin
            kind <= K_CMD;
            st   <= S_LOW;
          end else begin
            kind <= K_DATA;
            st   <= req_write ? S_LOW : S_RB;
          end
        end
        S_RB: if (nand_rb) st <= S_LOW;
        S_LOW:
          if (tmr == '0) begin
            if (rd_op) rsp_rdata[8*idx[1:0] +: 8] <= nand_io;
            tmr <= TW'(PULSE_HIGH - 1);
            st  <= S_HIGH;
          end else begin
            tmr <= tmr - 1'b1;
          end
        S_HIGH:
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (done_now) begin
            st <= S_IDLE;
            if (is_data && clr_cs) nand_ce_n <= '1;
            if (is_data && rd_q) rsp_valid <= 1'b1;
          end else begin
            tmr <= TW'(PULSE_LOW - 1);
            st  <= S_LOW;
            case (kind)
              K_CMD:
                if (naddr != 3'd0) kind <= K_ADDR;
                else               kind <= K_END;
              K_ADDR: begin
                if (idx + 3'd1 == naddr) kind <= K_END;
                else if (idx == 3'd3)    st   <= S_WAIT2;
                idx <= idx + 3'd1;
              end
              K_DATA:
                if (idx == 3'd3) kind <= K_END;
                else             idx  <= idx + 3'd1;
              default: ;
            endcase
          end
        S_WAIT2: if (req_valid) begin
          wbuf <= req_wdata;
          st   <= S_LOW;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_phase_seq_chk.sv
module nand_phase_seq_chk #(
  parameter int NUM_CE    = 4,
  parameter int PULSE_LOW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [NUM_CE-1:0] nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n
);
  logic [15:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (!nand_we_n) low_run <= low_run + 16'd1;
    else                 low_run <= '0;
  end

  assert_cle_ale_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_we_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (low_run == 16'(PULSE_LOW)));
  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !req_ready);
  assert_ce_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));
  assert_strobe_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !(&nand_ce_n));
endmodule

bind nand_phase_seq nand_phase_seq_chk #(.NUM_CE(NUM_CE), .PULSE_LOW(PULSE_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n)
);

// File: tb/nand_phase_seq_bench.sv
module nand_phase_seq_bench;
  localparam int NUM_CE = 4;
  localparam int PL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b1, nand_rb = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, ecc_last, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [31:0] rsp_rdata;
  logic [NUM_CE-1:0] nand_ce_n;
  wire  [7:0] nand_io;

  always #5 clk = ~clk;

  nand_phase_seq #(.NUM_CE(NUM_CE), .PULSE_LOW(PL), .PULSE_HIGH(1)) u_nand_phase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ecc_last(ecc_last),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io(nand_io), .nand_rb(nand_rb));

  logic [7:0] rd_pat [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
  logic [1:0] rd_idx = '0;
  assign nand_io = (!nand_re_n) ? rd_pat[rd_idx] : 8'hzz;

  int tests = 0, fails = 0;
  logic [9:0] seen [32];
  logic [9:0] expv [32];
  int nseen = 0, nexp = 0, re_falls = 0, bad_run = 0, both_latch = 0, we_run = 0;
  logic prev_we = 1'b1, prev_re = 1'b1, got_rsp = 1'b0;
  logic [31:0] rsp_word = '0;

  always @(negedge clk) begin
    if (prev_we && !nand_we_n) we_run = 0;
    if (!nand_we_n) we_run++;
    if (!prev_we && nand_we_n) begin
      if (we_run != PL) bad_run++;
      if (nseen < 32) seen[nseen] = {nand_cle, nand_ale, nand_io};
      nseen++;
    end
    if (prev_re && !nand_re_n) re_falls++;
    if (!prev_re && nand_re_n) rd_idx = rd_idx + 2'd1;
    if (nand_cle && nand_ale) both_latch++;
    if (rsp_valid) begin got_rsp = 1'b1; rsp_word = rsp_rdata; end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] e);
    expv[nexp] = e;
    nexp++;
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] w, input logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = w; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !req_ready; i++) @(negedge clk);
  endtask

  task automatic clear_log();
    nseen = 0; nexp = 0; re_falls = 0; got_rsp = 1'b0;
  endtask

  task automatic cmp_log(input string req);
    bit ok = (nseen == nexp);
    for (int i = 0; i < nexp && i < 32; i++) if (seen[i] !== expv[i]) ok = 0;
    chk(ok, req, {32'(nseen), 22'd0, seen[0]}, {32'(nexp), 22'd0, expv[0]});
  endtask

  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0380, 32'h0000_0000},
    {32'h0020_0480, 32'h0000_0000},
    {32'h00B1_8000, 32'h0403_0201},
    {32'h0180_0400, 32'hDDCC_BBAA},
    {32'h0118_8000, 32'h1122_3344},
    {32'h0128_0000, 32'hCAFE_F00D},
    {32'h03F7_0028, 32'h8765_4321},
    {32'h0240_07F8, 32'h0000_BEEF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nand_ce_n == '1 && !nand_cle && !nand_ale && nand_we_n && nand_re_n &&
        nand_io === 8'hzz && req_ready && !rsp_valid && !ecc_last,
        "R12 reset", {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, req_ready},
        {4'hF, 5'b00111});

    for (int v = 0; v < 8; v++) begin
      logic [31:0] a, w, w2;
      int na;
      a = VEC[v][63:32]; w = VEC[v][31:0]; w2 = ~w;
      na = a[19] ? 0 : int'(a[23:21]);
      clear_log();
      if (!a[19]) begin
        push({2'b10, a[10:3]});
        for (int i = 0; i < na; i++) push({2'b01, i < 4 ? w[8*i +: 8] : w2[8*(i-4) +: 8]});
      end else begin
        for (int i = 0; i < 4; i++) push({2'b00, w[8*i +: 8]});
      end
      if (a[20]) push({2'b10, a[18:11]});
      issue(a, w, 1'b1);
      chk(!req_ready, "R12 busy", {63'd0, req_ready}, 64'd0);
      if (na > 4) begin
        wait_ready();
        issue(32'hFFFF_FFFF, w2, 1'b1);
      end
      wait_ready();
      cmp_log(a[19] ? "R5/R4 data write" : (na > 4 ? "R3 long address" : "R2/R4 command"));
      if (a[19] && a[21])
        chk(nand_ce_n == '1, "R8 clear", {60'd0, nand_ce_n}, 64'hF);
      else
        chk(nand_ce_n == ~(4'(1) << a[25:24]), "R9/R8 select", {60'd0, nand_ce_n},
            {60'd0, ~(4'(1) << a[25:24])});
      chk(ecc_last == (a[19] & a[10]), "R10 command", {63'd0, ecc_last}, {63'd0, a[19] & a[10]});
    end

    clear_log();
    rd_idx = '0;
    nand_rb = 1'b0;
    issue(32'h0008_0400, 32'h0, 1'b0);
    repeat (20) @(negedge clk);
    chk(re_falls == 0 && nand_re_n, "R7 busy gate", 64'(re_falls), 64'd0);
    chk(ecc_last, "R10 data last", {63'd0, ecc_last}, 64'd1);
    chk(!req_ready, "R12 busy read", {63'd0, req_ready}, 64'd0);
    nand_rb = 1'b1;
    wait_ready();
    @(negedge clk);
    chk(got_rsp && rsp_word == 32'hD4C3_B2A1, "R6 read pack", {31'd0, got_rsp, rsp_word},
        {31'd0, 1'b1, 32'hD4C3_B2A1});
    chk(re_falls == 4 && nseen == 0, "R6/R1 read strobes", {32'(re_falls), 32'(nseen)}, {32'd4, 32'd0});
    chk(nand_ce_n == 4'b1110, "R8 hold", {60'd0, nand_ce_n}, 64'hE);

    clear_log();
    rd_idx = '0;
    push({2'b10, 8'h3F});
    issue(32'h0039_F800, 32'h0, 1'b0);
    wait_ready();
    @(negedge clk);
    cmp_log("R4 read end opcode");
    chk(got_rsp && rsp_word == 32'hD4C3_B2A1, "R6 second read", {32'd0, rsp_word}, {32'd0, 32'hD4C3_B2A1});
    chk(nand_ce_n == '1, "R8 read clear", {60'd0, nand_ce_n}, 64'hF);
    chk(ecc_last == 1'b0, "R10 cleared", {63'd0, ecc_last}, 64'd0);
    chk(bad_run == 0 && both_latch == 0, "R11 strobe timing", {32'(bad_run), 32'(both_latch)}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule